// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Baud Generator

This block sends asynchronous serial characters of 8 or 9 data bits on a single output line. Software places one character in a holding register. As soon as the shift register is free, the character moves into it and is clocked out. The holding register can therefore be refilled while the previous character is still on the line.

Each frame is one low start bit, then the data bits least significant first, then one high stop bit. The line rests high between frames. Bit timing comes from a built-in baud generator, which divides the system clock by (div+1) and then by a multiplier of 4, 16 or 64. The multiplier is chosen by two mode inputs. Two status outputs report whether the holding register and the shift register are empty. An interrupt request is raised when the holding register is empty and interrupts are enabled.

Top module: `sertx_top`

## Requirements
- R1: After reset, txd is 1, hold_empty is 1, shift_empty is 1 and no frame is in progress.
- R2: An 8-bit frame is driven on txd as a start bit of 0, then data bits 0 through 7, then a stop bit of 1. The line is 1 while no frame is in progress.
- R3: When nine_bit is 1 at the moment a character enters the shift register, the frame carries ninth_in as a ninth data bit after bit 7 and before the stop bit.
- R4: Every bit lasts (div+1)*M system clocks. M is 4 when sync_mode is 1, 16 when sync_mode is 0 and hi_speed is 1, and 64 when both are 0.
- R5: A hold_wr pulse clears hold_empty at the next edge. If the shift register is idle, the character transfers on the following edge: hold_empty returns to 1, shift_empty falls to 0 and the start bit begins.
- R6: If a character is waiting when a stop bit ends, its start bit follows at once, with no idle gap.
- R7: irq is 1 exactly when hold_empty is 1 and int_en is 1.
- R8: shift_empty is 0 from the start bit through the stop bit of a frame, and 1 otherwise.
- R9: While port_en or tx_en is 0, nothing is sent and a written character stays in the holding register (hold_empty stays 0). Sending starts one edge after both enables are 1.
- R10: Clearing tx_en during a frame aborts it. From the next edge, txd is 1 and shift_empty is 1.
- R11: A div_wr pulse loads div_val and restarts bit timing. The bit in progress ends (div_val+1)*M clocks after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable; clearing it aborts a frame |
| sync_mode | input | 1 | Selects multiplier 4 |
| hi_speed | input | 1 | In asynchronous mode, selects 16 (1) or 64 (0) |
| nine_bit | input | 1 | Enables the ninth data bit |
| div_val | input | 8 | Baud divider value n |
| div_wr | input | 1 | Loads div_val and restarts bit timing |
| hold_wr | input | 1 | Writes hold_data into the holding register |
| hold_data | input | 8 | Character to send |
| ninth_in | input | 1 | Ninth data bit, captured on transfer |
| int_en | input | 1 | Transmit interrupt enable |
| hold_empty | output | 1 | Holding register empty (transmit flag) |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register empty |
| txd | output | 1 | Serial output line |

## Verification
The bench covers each multiplier and several divider values, so a generator that confused 16 with 64 or dropped the +1 would move the stop-bit end and shift the mid-bit samples.

Back-to-back characters check that the second start bit follows the first stop bit directly. A design that waited for idle would leave a high gap, and one that transferred too early would corrupt the first frame.

Aborting mid-frame must return the line high on the next edge. Running with port_en low must keep the character held rather than dropping it. A divider rewrite in the middle of a long start bit must end that bit on the new short period; a design without the reload would keep the line low for hundreds of cycles.

// File: rtl/sertx_pkg.sv
// Shared types and helpers for the serial transmitter.
package sertx_pkg;

    // Shifter states
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_RUN  = 1'b1
    } tx_state_e;

    localparam int MULT_SYNC = 4;
    localparam int MULT_FAST = 16;
    localparam int MULT_SLOW = 64;
    localparam int MULT_W    = 6;

    // Terminal count of the multiplier stage (multiplier minus one)
    function automatic logic [MULT_W-1:0] mult_last(input logic sync_mode, input logic hi_speed);
        if (sync_mode)
            return MULT_W'(MULT_SYNC - 1);
        else if (hi_speed)
            return MULT_W'(MULT_FAST - 1);
        else
            return MULT_W'(MULT_SLOW - 1);
    endfunction

endpackage

// File: rtl/sertx_baud.sv
// Baud generator: a (div+1) prescaler followed by a mode-selected multiplier
// stage. Emits one-cycle bit_tick pulses while run is high.
// Assumes clr is pulsed whenever bit timing must restart (frame start).
module sertx_baud
    import sertx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             sync_mode,
    input  logic             hi_speed,
    input  logic [DIV_W-1:0] div_val,
    input  logic             div_wr,
    output logic             bit_tick
);

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  pre_cnt;
    logic [MULT_W-1:0] mul_cnt;
    logic [MULT_W-1:0] mul_end;
    logic              pre_tick;

    assign mul_end  = mult_last(sync_mode, hi_speed);
    assign pre_tick = run && (pre_cnt == div_q);
    assign bit_tick = pre_tick && (mul_cnt == mul_end);

    // Divider register: loaded on every divider write
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_wr)
            div_q <= div_val;
    end

    // Prescaler and multiplier counters, restarted on write, clear or idle
    always_ff @(posedge clk) begin
        if (!rst_n || div_wr || clr || !run) begin
            pre_cnt <= '0;
            mul_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            mul_cnt <= (mul_cnt == mul_end) ? '0 : mul_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sertx_hold.sv
// One-character holding register with its full flag.
// A write has priority over a transfer in the same cycle, so that a
// character written during a transfer is kept as the next one.
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_q,
    output logic              full
);

    // Full flag: set by a write, cleared by a transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (wr)
            full <= 1'b1;
        else if (take)
            full <= 1'b0;
    end

    // Data storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr)
            hold_q <= wr_data;
    end

endmodule

// File: rtl/sertx_shift.sv
// Transmit shift register and frame sequencer.
// Bit index 0 is the start bit, 1..DATA_W(+1) the data bits, and the last
// index the stop bit. Takes a character from the holding register when idle,
// or directly at the end of a stop bit. Disabling aborts at once.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_q,
    input  logic              ninth_in,
    input  logic              nine_bit,
    input  logic              bit_tick,
    output logic              load,
    output logic              busy,
    output logic              txd
);

    localparam int SH_W  = DATA_W + 1;
    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam logic [IDX_W-1:0] STOP8 = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] STOP9 = IDX_W'(DATA_W + 2);

    tx_state_e        state;
    logic [SH_W-1:0]  sh_q;
    logic [IDX_W-1:0] idx;
    logic             nine_q;
    logic [IDX_W-1:0] stop_idx;
    logic             at_stop;
    logic [IDX_W-1:0] data_sel;

    assign stop_idx = nine_q ? STOP9 : STOP8;
    assign at_stop  = (state == TX_RUN) && (idx == stop_idx);
    assign load     = run_en && hold_full &&
                      ((state == TX_IDLE) || (at_stop && bit_tick));
    assign busy     = (state == TX_RUN);
    assign data_sel = idx - 1'b1;

    // Frame sequencer: load, advance on bit ticks, abort when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            state  <= TX_IDLE;
            idx    <= '0;
            sh_q   <= '0;
            nine_q <= 1'b0;
        end else if (load) begin
            state  <= TX_RUN;
            idx    <= '0;
            sh_q   <= {ninth_in, hold_q};
            nine_q <= nine_bit;
        end else if (state == TX_RUN && bit_tick) begin
            if (at_stop) begin
                state <= TX_IDLE;
                idx   <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Line level chosen from the current bit position
    always_comb begin
        if (state == TX_IDLE)
            txd = 1'b1;
        else if (idx == '0)
            txd = 1'b0;
        else if (idx == stop_idx)
            txd = 1'b1;
        else
            txd = sh_q[data_sel];
    end

endmodule

// File: rtl/sertx_top.sv
// Double-buffered asynchronous serial transmitter.
// Connects the holding register, the shift sequencer and the baud generator.
// Assumes all inputs are synchronous to clk.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic              hi_speed,
    input  logic              nine_bit,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              div_wr,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              ninth_in,
    input  logic              int_en,
    output logic              hold_empty,
    output logic              irq,
    output logic              shift_empty,
    output logic              txd
);

    logic              run_en;
    logic              load;
    logic              busy;
    logic              bit_tick;
    logic              hold_full;
    logic [DATA_W-1:0] hold_q;

    assign run_en      = port_en && tx_en;
    assign hold_empty  = !hold_full;
    assign irq         = hold_empty && int_en;
    assign shift_empty = !busy;

    sertx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hold_wr),
        .wr_data (hold_data),
        .take    (load),
        .hold_q  (hold_q),
        .full    (hold_full)
    );

    sertx_shift #(.DATA_W(DATA_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .hold_full (hold_full),
        .hold_q    (hold_q),
        .ninth_in  (ninth_in),
        .nine_bit  (nine_bit),
        .bit_tick  (bit_tick),
        .load      (load),
        .busy      (busy),
        .txd       (txd)
    );

    sertx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .clr       (load),
        .sync_mode (sync_mode),
        .hi_speed  (hi_speed),
        .div_val   (div_val),
        .div_wr    (div_wr),
        .bit_tick  (bit_tick)
    );

endmodule

// File: rtl/sertx_chk.sv
// Port-level property checker for sertx_top, attached by bind.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic tx_en,
    input logic hold_wr,
    input logic int_en,
    input logic hold_empty,
    input logic irq,
    input logic shift_empty,
    input logic txd
);

    // R8 / R2: idle line rests high
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

    // R5: a frame begins with a low start bit
    assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !txd);

    // R5: a write fills the holding register
    assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> !hold_empty);

    // R7: masked interrupt stays low
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);

    // R7: enabled interrupt follows an empty holding register
    assert_irq_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_empty && int_en) |-> irq);

    // R10: clearing transmit enable aborts and idles the line
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (shift_empty && txd));

    // R9: port disable keeps the shifter empty
    assert_port_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> shift_empty);

endmodule

bind sertx_top sertx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .tx_en       (tx_en),
    .hold_wr     (hold_wr),
    .int_en      (int_en),
    .hold_empty  (hold_empty),
    .irq         (irq),
    .shift_empty (shift_empty),
    .txd         (txd)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // Vector: {nine_bit, hi_speed, sync_mode, div[7:0], data[7:0], ninth}
    localparam logic [19:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 8'd3, 8'hA5, 1'b0},
        {1'b0, 1'b0, 1'b0, 8'd1, 8'h3C, 1'b0},
        {1'b0, 1'b0, 1'b1, 8'd5, 8'h81, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd0, 8'h5A, 1'b1},
        {1'b1, 1'b0, 1'b1, 8'd2, 8'hFF, 1'b0},
        {1'b0, 1'b1, 1'b0, 8'd0, 8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1;
    logic       tx_en = 1'b1;
    logic       sync_mode = 1'b0;
    logic       hi_speed = 1'b1;
    logic       nine_bit = 1'b0;
    logic [7:0] div_val = '0;
    logic       div_wr = 1'b0;
    logic       hold_wr = 1'b0;
    logic [7:0] hold_data = '0;
    logic       ninth_in = 1'b0;
    logic       int_en = 1'b0;
    logic       hold_empty;
    logic       irq;
    logic       shift_empty;
    logic       txd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
        .sync_mode(sync_mode), .hi_speed(hi_speed), .nine_bit(nine_bit),
        .div_val(div_val), .div_wr(div_wr), .hold_wr(hold_wr),
        .hold_data(hold_data), .ninth_in(ninth_in), .int_en(int_en),
        .hold_empty(hold_empty), .irq(irq), .shift_empty(shift_empty), .txd(txd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Write the divider; returns at a negedge
    task automatic set_div(input logic [7:0] d);
        @(negedge clk);
        div_val = d; div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    // Pulse a character write; returns at the negedge after the write edge
    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        hold_data = d; hold_wr = 1'b1;
        @(negedge clk);
        hold_wr = 1'b0;
    endtask

    // Walk a whole frame from the negedge following the write edge
    task automatic check_frame(input logic [7:0] d, input logic n9, input logic b9, input int p);
        int nb;
        logic [10:0] exp_bits;
        nb = b9 ? 11 : 10;
        exp_bits = b9 ? {1'b1, n9, d, 1'b0} : {1'b0, 1'b1, d, 1'b0};
        chk("R5 hold_empty low after write", int'(hold_empty), 0);
        for (int b = 0; b < nb; b++) begin
            for (int j = 1; j <= p; j++) begin
                @(negedge clk);
                if (b == 0 && j == 1) begin
                    chk("R5 hold_empty set on transfer", int'(hold_empty), 1);
                    chk("R8 shift_empty low in frame", int'(shift_empty), 0);
                end
                if (j == p / 2)
                    chk(b9 ? "R3 nine-bit frame bit" : "R2 frame bit", int'(txd), int'(exp_bits[b]));
            end
        end
        chk("R4 busy through last stop cycle", int'(shift_empty), 0);
        @(negedge clk);
        chk("R4 idle right after stop", int'(shift_empty), 1);
        chk("R8 line high when idle", int'(txd), 1);
    endtask

    // Wait for idle with a bound
    task automatic wait_idle();
        for (int i = 0; i < 20000 && !shift_empty; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 txd after reset", int'(txd), 1);
        chk("R1 hold_empty after reset", int'(hold_empty), 1);
        chk("R1 shift_empty after reset", int'(shift_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd idle after release", int'(txd), 1);

        // Table walk: R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            int mul;
            int per;
            nine_bit  = VECS[v][19];
            hi_speed  = VECS[v][18];
            sync_mode = VECS[v][17];
            ninth_in  = VECS[v][0];
            mul = sync_mode ? 4 : (hi_speed ? 16 : 64);
            per = (int'(VECS[v][16:9]) + 1) * mul;
            set_div(VECS[v][16:9]);
            write_char(VECS[v][8:1]);
            check_frame(VECS[v][8:1], VECS[v][0], VECS[v][19], per);
        end

        // R7 interrupt gating
        nine_bit = 1'b0; sync_mode = 1'b0; hi_speed = 1'b1;
        int_en = 1'b0;
        @(negedge clk);
        chk("R7 irq masked", int'(irq), 0);
        int_en = 1'b1;
        @(negedge clk);
        chk("R7 irq raised when empty", int'(irq), 1);

        // R9 port disabled: character held, nothing sent
        set_div(8'd0);
        port_en = 1'b0;
        write_char(8'h55);
        repeat (40) @(negedge clk);
        chk("R9 no frame while disabled", int'(shift_empty), 1);
        chk("R9 line high while disabled", int'(txd), 1);
        chk("R9 character held", int'(hold_empty), 0);
        chk("R7 irq low while full", int'(irq), 0);
        port_en = 1'b1;
        @(negedge clk);
        chk("R9 frame starts after enable", int'(shift_empty), 0);
        chk("R9 start bit after enable", int'(txd), 0);
        wait_idle();

        // R6 back-to-back characters, P = 16
        write_char(8'hC3);
        @(negedge clk);                   // j = 1
        hold_data = 8'h96; hold_wr = 1'b1;
        @(negedge clk);                   // j = 2
        hold_wr = 1'b0;
        repeat (16 * 10 - 2) @(negedge clk);  // j = 160, last stop cycle
        chk("R6 first stop bit high", int'(txd), 1);
        chk("R6 second char waiting", int'(hold_empty), 0);
        @(negedge clk);                   // j = 161
        chk("R6 second start bit immediate", int'(txd), 0);
        chk("R6 shifter stays busy", int'(shift_empty), 0);
        chk("R6 second char taken", int'(hold_empty), 1);
        for (int b = 0; b < 8; b++) begin
            logic [7:0] d2;
            d2 = 8'h96;
            repeat (16) @(negedge clk);
            chk("R6 second frame data", int'(txd), int'(d2[b]));
        end
        wait_idle();

        // R10 abort mid-frame
        write_char(8'h00);
        repeat (30) @(negedge clk);
        chk("R10 frame in progress", int'(shift_empty), 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R10 aborted shifter empty", int'(shift_empty), 1);
        chk("R10 aborted line high", int'(txd), 1);
        tx_en = 1'b1;
        @(negedge clk);

        // R11 divider reload mid start bit
        sync_mode = 1'b1;
        set_div(8'd200);
        write_char(8'h01);                // now at j = 0
        repeat (10) @(negedge clk);       // j = 10
        div_val = 8'd1; div_wr = 1'b1;
        @(negedge clk);                   // j = 11
        div_wr = 1'b0;
        repeat (7) @(negedge clk);        // j = 18
        chk("R11 start bit still low", int'(txd), 0);
        @(negedge clk);                   // j = 19
        chk("R11 new period ends start bit", int'(txd), 1);
        wait_idle();
        chk("R11 frame completes", int'(shift_empty), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule